// File: doc/BRIEF.md
# Two-Level Interrupt Collector with Selectable Line Polarity

This block gathers interrupt events into two groups and reports them on one output line. The first group is a 32-bit USB-core group. The second is a 32-bit DMA group. Each group has a pending-source register, which software changes by writing a set address or a clear address, and a mask register. The groups reduce to three summary bits in a 32-bit top-level source register. Bit 9 summarises the low half of the core group, bit 8 summarises the high half of the core group, and bit 24 summarises the DMA group. The top level has its own set, clear and mask addresses. It also takes raw event inputs, and each event drives one top-level bit to the level it carries.

The output line has two encodings, chosen by bit 17 of a configuration register. In the active-high encoding the line is high while any unmasked top-level bit is pending. In the inverted encoding the line is high only while nothing unmasked is pending. A power-good qualifier gates the line in both encodings. All summaries and the line are combinational functions of the registered state, so a register write becomes visible in the cycle after the clock edge that captures it. Reads are combinational from the word address.

Top module: `irq_collector`

## Requirements
- R1: A write to a set address ORs the write data into that group's source register. Word addresses are: 0 config; 1 top source, 2 top set, 3 top clear, 4 top mask; 5 core source, 6 core set, 7 core clear, 8 core mask; 9 DMA source, 10 DMA set, 11 DMA clear, 12 DMA mask.
- R2: A write to a clear address clears every source bit that is 1 in the write data and leaves the other bits unchanged.
- R3: A write to a mask address stores the data in that mask register, and reading the mask address returns it. A mask bit of 1 blocks the matching source bit.
- R4: Top-level bit 9 is 1 exactly when some bit in core source bits 15:0 is pending and unmasked.
- R5: Top-level bit 8 is 1 exactly when some bit in core source bits 31:16 is pending and unmasked.
- R6: Top-level bit 24 is 1 exactly when some DMA source bit is pending and unmasked.
- R7: Top-level bits 8, 9 and 24 always follow their group condition. A top-level set write or clear write has no effect on them.
- R8: When config bit 17 is 1, irq_out is high while any top-level bit is pending and unmasked.
- R9: When config bit 17 is 0, irq_out is high only while no top-level bit is pending and unmasked.
- R10: While pwr_ok is low, irq_out is low in both encodings.
- R11: After reset, the top mask is all ones, the group masks are zero, and all sources and the config register are zero.
- R12: A cycle with evt_valid high sets top-level bit evt_idx when evt_level is 1 and clears that bit when evt_level is 0.
- R13: Reading a set address or a clear address returns that group's current source value. Writes to a source address are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, together with bus_sel |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_valid | input | 1 | Raw event strobe |
| evt_idx | input | 5 | Top-level bit the event drives |
| evt_level | input | 1 | Level the event drives: 1 sets the bit, 0 clears it |
| pwr_ok | input | 1 | Power-good qualifier for the output line |
| irq_out | output | 1 | Interrupt line |

## Verification
The register-update properties assume a set or clear write does not land in the same cycle as a raw event that pulls the same bits the other way. The antecedents exclude such overlaps, and the stimulus never issues an event while a bus write is in flight. The properties also assume that bus_addr, bus_we and bus_sel are stable for the full cycle a write is captured. The bench drives every bus field once, just after a rising edge, and holds it until the next edge.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_CFG       = 4'd0,
    RA_TOP_SRC   = 4'd1,
    RA_TOP_SET   = 4'd2,
    RA_TOP_CLR   = 4'd3,
    RA_TOP_MASK  = 4'd4,
    RA_CORE_SRC  = 4'd5,
    RA_CORE_SET  = 4'd6,
    RA_CORE_CLR  = 4'd7,
    RA_CORE_MASK = 4'd8,
    RA_DMA_SRC   = 4'd9,
    RA_DMA_SET   = 4'd10,
    RA_DMA_CLR   = 4'd11,
    RA_DMA_MASK  = 4'd12
  } reg_addr_e;

  // next value of a source register under a set/clear write and event strobes
  function automatic logic [DATA_W-1:0] src_next(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] set_bits,
      input logic [DATA_W-1:0] clr_bits,
      input logic [DATA_W-1:0] ev_set,
      input logic [DATA_W-1:0] ev_clr);
    logic [DATA_W-1:0] tmp;
    tmp = (cur | set_bits) & ~clr_bits;
    return (tmp | ev_set) & ~ev_clr;
  endfunction

  // any bit pending and not blocked
  function automatic logic any_live(
      input logic [DATA_W-1:0] src,
      input logic [DATA_W-1:0] mask);
    return |(src & ~mask);
  endfunction

  // output line level from encoding, live state and qualifier
  function automatic logic line_level(
      input logic active_high,
      input logic live,
      input logic qualify);
    return qualify & (active_high ? live : ~live);
  endfunction

endpackage

// File: rtl/irq_src_group.sv
module irq_src_group
  import irq_collector_pkg::*;
#(
  parameter int              W        = DATA_W,
  parameter logic [W-1:0]    MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] evt_clr,
  output logic [W-1:0] src_q,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;
  logic [W-1:0] src_d;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;
  assign src_d    = src_next(src_q, set_bits, clr_bits, evt_set, evt_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= MASK_RST;
    end else begin
      src_q <= src_d;
      if (mask_we) mask_q <= wdata;
    end
  end

  // R1
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && evt_clr == '0) |=> ((src_q & $past(wdata)) == $past(wdata)));

  // R2
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt_set == '0) |=> ((src_q & $past(wdata)) == '0));

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata)));

  // R12
  evt_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0 && !clr_we) |=> ((src_q & $past(evt_set)) == $past(evt_set)));

endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
  import irq_collector_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_high,
  input  logic [DATA_W-1:0] top_src,
  input  logic [DATA_W-1:0] top_mask,
  input  logic              pwr_ok,
  output logic              irq_out
);

  logic live;

  assign live    = any_live(top_src, top_mask);
  assign irq_out = line_level(active_high, live, pwr_ok);

  // R10
  qualify_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !irq_out);

endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int TX_BIT  = 9,
  parameter int RX_BIT  = 8,
  parameter int DMA_BIT = 24,
  parameter int POL_BIT = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_valid,
  input  logic [$clog2(DATA_W)-1:0] evt_idx,
  input  logic              evt_level,
  input  logic              pwr_ok,
  output logic              irq_out
);

  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] SUM_BITS =
    (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << RX_BIT) | (DATA_W'(1) << DMA_BIT);

  logic wr;
  assign wr = bus_sel & bus_we;

  // configuration register
  logic [DATA_W-1:0] cfg_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                    cfg_q <= '0;
    else if (wr && bus_addr == RA_CFG) cfg_q <= bus_wdata;
  end

  // raw event decode onto top-level bits
  logic [DATA_W-1:0] ev_set, ev_clr;
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_evt
      assign ev_set[i] = evt_valid && (evt_idx == i) &&  evt_level;
      assign ev_clr[i] = evt_valid && (evt_idx == i) && !evt_level;
    end
  endgenerate

  logic [DATA_W-1:0] core_src, core_mask, dma_src, dma_mask, top_raw, top_mask;

  irq_src_group #(.W(DATA_W), .MASK_RST('0)) u_core (
    .clk(clk), .rst_n(rst_n),
    .set_we (wr && bus_addr == RA_CORE_SET),
    .clr_we (wr && bus_addr == RA_CORE_CLR),
    .mask_we(wr && bus_addr == RA_CORE_MASK),
    .wdata(bus_wdata), .evt_set('0), .evt_clr('0),
    .src_q(core_src), .mask_q(core_mask));

  irq_src_group #(.W(DATA_W), .MASK_RST('0)) u_dma (
    .clk(clk), .rst_n(rst_n),
    .set_we (wr && bus_addr == RA_DMA_SET),
    .clr_we (wr && bus_addr == RA_DMA_CLR),
    .mask_we(wr && bus_addr == RA_DMA_MASK),
    .wdata(bus_wdata), .evt_set('0), .evt_clr('0),
    .src_q(dma_src), .mask_q(dma_mask));

  irq_src_group #(.W(DATA_W), .MASK_RST('1)) u_top (
    .clk(clk), .rst_n(rst_n),
    .set_we (wr && bus_addr == RA_TOP_SET),
    .clr_we (wr && bus_addr == RA_TOP_CLR),
    .mask_we(wr && bus_addr == RA_TOP_MASK),
    .wdata(bus_wdata), .evt_set(ev_set), .evt_clr(ev_clr),
    .src_q(top_raw), .mask_q(top_mask));

  // summaries, named for the assertions
  logic core_tx_any, core_rx_any, dma_any;
  assign core_tx_any = any_live({{HALF{1'b0}}, core_src[HALF-1:0]},
                                {{HALF{1'b1}}, core_mask[HALF-1:0]});
  assign core_rx_any = any_live({core_src[DATA_W-1:HALF], {HALF{1'b0}}},
                                {core_mask[DATA_W-1:HALF], {HALF{1'b1}}});
  assign dma_any     = any_live(dma_src, dma_mask);

  logic [DATA_W-1:0] top_eff;
  always_comb begin
    top_eff          = top_raw & ~SUM_BITS;
    top_eff[TX_BIT]  = core_tx_any;
    top_eff[RX_BIT]  = core_rx_any;
    top_eff[DMA_BIT] = dma_any;
  end

  irq_line_drv u_line (
    .clk(clk), .rst_n(rst_n),
    .active_high(cfg_q[POL_BIT]),
    .top_src(top_eff), .top_mask(top_mask),
    .pwr_ok(pwr_ok), .irq_out(irq_out));

  // read mux
  always_comb begin
    case (bus_addr)
      RA_CFG:                               bus_rdata = cfg_q;
      RA_TOP_SRC, RA_TOP_SET, RA_TOP_CLR:   bus_rdata = top_eff;
      RA_TOP_MASK:                          bus_rdata = top_mask;
      RA_CORE_SRC, RA_CORE_SET, RA_CORE_CLR: bus_rdata = core_src;
      RA_CORE_MASK:                         bus_rdata = core_mask;
      RA_DMA_SRC, RA_DMA_SET, RA_DMA_CLR:   bus_rdata = dma_src;
      RA_DMA_MASK:                          bus_rdata = dma_mask;
      default:                              bus_rdata = '0;
    endcase
  end

  // R4
  tx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_eff[TX_BIT] == (|(core_src[HALF-1:0] & ~core_mask[HALF-1:0])));

  // R5
  rx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_eff[RX_BIT] == (|(core_src[DATA_W-1:HALF] & ~core_mask[DATA_W-1:HALF])));

  // R6
  dma_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_eff[DMA_BIT] == (|(dma_src & ~dma_mask)));

  // R8
  line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && cfg_q[POL_BIT] && (top_eff & ~top_mask) != '0) |-> irq_out);

  // R9
  line_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !cfg_q[POL_BIT]) |-> (irq_out == ((top_eff & ~top_mask) == '0)));

endmodule

// File: tb/tb_irq_collector.sv
module tb_irq_collector;
  import irq_collector_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              evt_valid = 1'b0;
  logic [4:0]        evt_idx = '0;
  logic              evt_level = 1'b0;
  logic              pwr_ok = 1'b1;
  logic              irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_level(evt_level),
    .pwr_ok(pwr_ok), .irq_out(irq_out));

  typedef struct {
    bit          is_line;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  logic      chk_req = 1'b0;
  int        checks = 0;
  int        errors = 0;
  bit        done = 1'b0;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (chk_req && exp_q.size() > 0) begin
      exp_item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.is_line ? {31'b0, irq_out} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic bus_write(input reg_addr_e a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic expect_reg(input reg_addr_e a, input logic [31:0] e, input string tag);
    exp_item_t it;
    bus_addr = a;
    it.is_line = 1'b0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic expect_line(input logic e, input string tag);
    exp_item_t it;
    it.is_line = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic raw_event(input int idx, input logic lvl);
    @(posedge clk); #1;
    evt_valid = 1'b1; evt_idx = 5'(idx); evt_level = lvl;
    @(posedge clk); #1;
    evt_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    expect_reg(RA_TOP_MASK, 32'hFFFF_FFFF, "R11 top mask");
    expect_reg(RA_TOP_SRC, 32'h0, "R11 top source");
    expect_reg(RA_CFG, 32'h0, "R11 config");
    expect_reg(RA_CORE_MASK, 32'h0, "R11 core mask");
    expect_line(1'b1, "R9 R11 inverted idle line");
    pwr_ok = 1'b0;
    expect_line(1'b0, "R10 qualifier low");
    pwr_ok = 1'b1;

    // active-high encoding
    bus_write(RA_CFG, 32'h0002_0000);
    expect_line(1'b0, "R8 all masked");
    bus_write(RA_CORE_SET, 32'h0000_0004);
    expect_reg(RA_CORE_SRC, 32'h0000_0004, "R1 core set");
    expect_reg(RA_CORE_SET, 32'h0000_0004, "R13 read set addr");
    expect_reg(RA_CORE_CLR, 32'h0000_0004, "R13 read clear addr");
    expect_reg(RA_TOP_SRC, 32'h0000_0200, "R4 tx summary");
    bus_write(RA_TOP_MASK, 32'hFFFF_FDFF);
    expect_line(1'b1, "R8 unmasked tx");
    pwr_ok = 1'b0;
    expect_line(1'b0, "R10 qualifier gates active-high");
    pwr_ok = 1'b1;

    bus_write(RA_CORE_MASK, 32'h0000_FFFF);
    expect_reg(RA_CORE_MASK, 32'h0000_FFFF, "R3 mask readback");
    expect_reg(RA_TOP_SRC, 32'h0, "R4 tx masked");
    expect_line(1'b0, "R8 nothing live");

    bus_write(RA_CORE_SET, 32'h0001_0000);
    expect_reg(RA_TOP_SRC, 32'h0000_0100, "R5 rx summary");
    bus_write(RA_CORE_CLR, 32'h0001_0000);
    expect_reg(RA_CORE_SRC, 32'h0000_0004, "R2 core clear");
    expect_reg(RA_TOP_SRC, 32'h0, "R5 rx drops");

    bus_write(RA_DMA_SET, 32'h0000_0080);
    expect_reg(RA_TOP_SRC, 32'h0100_0000, "R6 dma summary");
    bus_write(RA_DMA_MASK, 32'h0000_0080);
    expect_reg(RA_TOP_SRC, 32'h0, "R6 dma masked");
    bus_write(RA_DMA_MASK, 32'h0);

    bus_write(RA_TOP_CLR, 32'h0100_0000);
    expect_reg(RA_TOP_SRC, 32'h0100_0000, "R7 clear ignored on summary");
    bus_write(RA_TOP_SET, 32'h0000_0200);
    expect_reg(RA_TOP_SRC, 32'h0100_0000, "R7 set ignored on summary");

    bus_write(RA_CORE_SRC, 32'hFFFF_FFFF);
    expect_reg(RA_CORE_SRC, 32'h0000_0004, "R13 source write ignored");

    raw_event(3, 1'b1);
    expect_reg(RA_TOP_SRC, 32'h0100_0008, "R12 event sets");
    raw_event(3, 1'b0);
    expect_reg(RA_TOP_SRC, 32'h0100_0000, "R12 event clears");

    // inverted encoding
    bus_write(RA_CFG, 32'h0);
    bus_write(RA_TOP_MASK, 32'hFEFF_FDFF);
    expect_line(1'b0, "R9 pending drops line");
    bus_write(RA_DMA_CLR, 32'h0000_0080);
    expect_line(1'b1, "R9 idle raises line");

    bus_write(RA_TOP_SET, 32'h0000_0001);
    expect_reg(RA_TOP_SRC, 32'h0000_0001, "R1 top set");
    bus_write(RA_TOP_CLR, 32'h0000_0001);
    expect_reg(RA_TOP_SRC, 32'h0, "R2 top clear");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule